// File: doc/BRIEF.md
# Command Stream Opcode Decoder

This block parses a stream of 32-bit command words arriving one per cycle under a valid/ready handshake. The first word it sees, and every word after a run of payload words has ended, is treated as a header. The top nibble of a header selects its kind. The block pulls out the fields that belong to that kind and reports them as one decoded-header record. These fields are the class, the register offset, the mask, the count, the immediate data, the lock index, the gather flags and the jump target.

From each header the block also works out how many payload words follow. For some kinds this is a count field. For the two masked kinds it is the number of set mask bits. A gather is always followed by one word, and every other kind has none. The block then tags each payload word with the register it is aimed at, so a downstream register-write engine can consume the stream without parsing it again. Register writes, gather fetches and jumps are not carried out here: they only appear as decoded records. The input is always ready, and every result is registered.

Top module: `cmd_stream_decoder`

## Requirements
- R1: The opcode is taken from word bits 31:28 (0 class select, 1 stepping write, 2 fixed write, 3 masked write, 4 immediate, 5 jump, 6 gather, 14 extended). An accepted header raises `hdr_valid` for one cycle in the cycle after it is accepted, with `hdr_op` equal to the opcode. `hdr_valid` and `pay_valid` are never high together.
- R2: A stepping write (1) reports offset bits 27:16 and count bits 15:0. It is followed by that many payload words. The payload offset starts at the header offset and rises by one per word, wrapping modulo 4096.
- R3: A fixed write (2) decodes like R2, but every payload word carries the header offset.
- R4: A masked write (3) reports offset bits 27:16 and mask bits 15:0. It has one payload word per set mask bit. The words are taken in ascending bit order, and each goes to the header offset plus that bit's index, modulo 4096. A zero mask gives no payload.
- R5: A class select (0) reports class bits 15:6, offset bits 27:16 and a 6-bit mask from bits 5:0. Its payload follows the R4 rule. A zero mask is a pure class change with no payload.
- R6: An immediate (4) reports offset bits 27:16 and data bits 15:0, and has no payload.
- R7: A jump (5) reports a target equal to the header word shifted left by four bits (32 bits kept), and has no payload.
- R8: A gather (6) reports offset bits 27:16, insert flag bit 15, type flag bit 14 and count bits 13:0. It is followed by exactly one payload word, which carries the header offset.
- R9: An extended header (14) uses sub-opcode bits 27:24. Sub-opcode 0 sets `hdr_lock_acq` and sub-opcode 1 sets `hdr_lock_rel`, each with the lock index taken from bits 7:0. Any other sub-opcode sets `hdr_err`. No extended header has a payload.
- R10: Opcodes 7 to 13 and 15 set `hdr_err` and have no payload. The next word is parsed as a header.
- R11: A cycle with `in_valid` low produces no output strobe and leaves the parse state unchanged.
- R12: While `rst` is high at a clock edge, both strobes clear and the parser returns to expecting a header, even in the middle of a payload run.
- R13: `hdr_plen` gives the payload length. Each payload strobe carries the word as `pay_data`, and `pay_last` is high on the final payload word of a run.
- R14: Every header field that does not belong to the decoded opcode reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Always high; a word is accepted whenever valid |
| in_word | input | 32 | Command word |
| hdr_valid | output | 1 | Decoded header strobe |
| hdr_op | output | 4 | Opcode |
| hdr_class | output | 10 | Class (class select only) |
| hdr_offset | output | 12 | Register offset |
| hdr_mask | output | 16 | Write mask (6 bits used for class select) |
| hdr_count | output | 16 | Word count field |
| hdr_imm | output | 16 | Immediate data |
| hdr_lock | output | 8 | Lock index |
| hdr_lock_acq | output | 1 | Lock acquire |
| hdr_lock_rel | output | 1 | Lock release |
| hdr_insert | output | 1 | Gather insert flag |
| hdr_type | output | 1 | Gather type flag |
| hdr_target | output | 32 | Jump target |
| hdr_plen | output | 16 | Payload words following |
| hdr_err | output | 1 | Unknown opcode or sub-opcode |
| pay_valid | output | 1 | Payload strobe |
| pay_offset | output | 12 | Target register of the payload word |
| pay_data | output | 32 | Payload word |
| pay_last | output | 1 | Final payload word of the run |

## Verification
The result for each accepted word, whether a header record or a payload strobe with its offset and last flag, is due exactly one clock edge after the edge that accepts it. The bench drives each word on a falling edge, lets one rising edge pass, and compares the outputs at the following falling edge against its reference model. The model keeps a queue of the offsets it expects for the pending payload words. An idle cycle or a reset is due on that same next edge, so the bench checks that both strobes are low there and that the following word is classified from the model's own queue state.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 4;
  localparam int OFF_W  = 12;
  localparam int CLS_W  = 10;
  localparam int CNT_W  = 16;
  localparam int LOCK_W = 8;
  localparam int MASK_W = 16;
  localparam int IDX_W  = $clog2(MASK_W);
  localparam int SHIFT_TGT = 4;

  localparam logic [OP_W-1:0] OPC_CLASS  = 4'd0;
  localparam logic [OP_W-1:0] OPC_STEP   = 4'd1;
  localparam logic [OP_W-1:0] OPC_FIXED  = 4'd2;
  localparam logic [OP_W-1:0] OPC_MASKED = 4'd3;
  localparam logic [OP_W-1:0] OPC_IMM    = 4'd4;
  localparam logic [OP_W-1:0] OPC_JUMP   = 4'd5;
  localparam logic [OP_W-1:0] OPC_GATHER = 4'd6;
  localparam logic [OP_W-1:0] OPC_EXT    = 4'd14;

  localparam logic [3:0] SUB_ACQ = 4'd0;
  localparam logic [3:0] SUB_REL = 4'd1;

  typedef enum logic [1:0] {RUN_FIX, RUN_INC, RUN_MASK} run_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [CLS_W-1:0]  cls;
    logic [OFF_W-1:0]  off;
    logic [MASK_W-1:0] mask;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  imm;
    logic [LOCK_W-1:0] lock;
    logic              acq;
    logic              rel;
    logic              ins;
    logic              typ;
    logic [WORD_W-1:0] target;
    logic [CNT_W-1:0]  plen;
    logic              err;
  } hdr_t;

  // number of set bits in a mask
  function automatic logic [IDX_W:0] ones_in(input logic [MASK_W-1:0] m);
    logic [IDX_W:0] s;
    s = '0;
    for (int i = 0; i < MASK_W; i++) s = s + (IDX_W+1)'(m[i]);
    return s;
  endfunction

  // index of the lowest set bit (0 when mask is empty)
  function automatic logic [IDX_W-1:0] lowest_idx(input logic [MASK_W-1:0] m);
    logic [IDX_W-1:0] k;
    k = '0;
    for (int i = MASK_W-1; i >= 0; i--) if (m[i]) k = IDX_W'(i);
    return k;
  endfunction
endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
  import cmd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr,
  output run_e              mode
);
  logic [OP_W-1:0] op_w;
  logic [3:0]      sub_w;
  assign op_w  = word[31:28];
  assign sub_w = word[27:24];

  always_comb begin
    hdr    = '0;
    mode   = RUN_FIX;
    hdr.op = op_w;
    case (op_w)
      OPC_CLASS: begin
        hdr.cls  = word[15:6];
        hdr.off  = word[27:16];
        hdr.mask = MASK_W'(word[5:0]);
        hdr.plen = CNT_W'(ones_in(MASK_W'(word[5:0])));
        mode     = RUN_MASK;
      end
      OPC_STEP, OPC_FIXED: begin
        hdr.off  = word[27:16];
        hdr.cnt  = word[15:0];
        hdr.plen = word[15:0];
        mode     = (op_w == OPC_STEP) ? RUN_INC : RUN_FIX;
      end
      OPC_MASKED: begin
        hdr.off  = word[27:16];
        hdr.mask = word[15:0];
        hdr.plen = CNT_W'(ones_in(word[15:0]));
        mode     = RUN_MASK;
      end
      OPC_IMM: begin
        hdr.off = word[27:16];
        hdr.imm = word[15:0];
      end
      OPC_JUMP: hdr.target = {word[WORD_W-1-SHIFT_TGT:0], SHIFT_TGT'(0)};
      OPC_GATHER: begin
        hdr.off  = word[27:16];
        hdr.ins  = word[15];
        hdr.typ  = word[14];
        hdr.cnt  = CNT_W'(word[13:0]);
        hdr.plen = CNT_W'(1);
      end
      OPC_EXT: begin
        if (sub_w == SUB_ACQ) begin
          hdr.acq  = 1'b1;
          hdr.lock = word[7:0];
        end else if (sub_w == SUB_REL) begin
          hdr.rel  = 1'b1;
          hdr.lock = word[7:0];
        end else begin
          hdr.err = 1'b1;
        end
      end
      default: hdr.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmd_run_tracker.sv
module cmd_run_tracker
  import cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [CNT_W-1:0]  hdr_plen,
  input  run_e              hdr_mode,
  input  logic [OFF_W-1:0]  hdr_off,
  input  logic [MASK_W-1:0] hdr_mask,
  output logic              in_run,
  output logic [OFF_W-1:0]  run_off,
  output logic              run_last,
  output run_e              run_mode
);
  logic [CNT_W-1:0]  rem_q;
  logic [OFF_W-1:0]  off_q;
  logic [MASK_W-1:0] mask_q;
  run_e              mode_q;
  logic [IDX_W-1:0]  next_bit;

  assign next_bit = lowest_idx(mask_q);
  assign in_run   = (rem_q != '0);
  assign run_last = (rem_q == CNT_W'(1));
  assign run_mode = mode_q;
  assign run_off  = (mode_q == RUN_MASK) ? off_q + OFF_W'(next_bit) : off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      off_q  <= '0;
      mask_q <= '0;
      mode_q <= RUN_FIX;
    end else if (accept) begin
      if (in_run) begin
        rem_q <= rem_q - CNT_W'(1);
        if (mode_q == RUN_INC) off_q <= off_q + OFF_W'(1);
        if (mode_q == RUN_MASK) mask_q <= mask_q & ~(MASK_W'(1) << next_bit);
      end else begin
        rem_q  <= hdr_plen;
        off_q  <= hdr_off;
        mask_q <= hdr_mask;
        mode_q <= hdr_mode;
      end
    end
  end

  // R4: in a mask run the bits still set match the words still owed
  p_mask_matches_rem_r4: assert property (@(posedge clk) disable iff (rst)
    (in_run && mode_q == RUN_MASK) |-> (CNT_W'(ones_in(mask_q)) == rem_q));

  // R11: an idle cycle leaves the remaining count untouched
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!accept) |=> $stable(rem_q));
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              hdr_valid,
  output logic [3:0]        hdr_op,
  output logic [9:0]        hdr_class,
  output logic [11:0]       hdr_offset,
  output logic [15:0]       hdr_mask,
  output logic [15:0]       hdr_count,
  output logic [15:0]       hdr_imm,
  output logic [7:0]        hdr_lock,
  output logic              hdr_lock_acq,
  output logic              hdr_lock_rel,
  output logic              hdr_insert,
  output logic              hdr_type,
  output logic [31:0]       hdr_target,
  output logic [15:0]       hdr_plen,
  output logic              hdr_err,
  output logic              pay_valid,
  output logic [11:0]       pay_offset,
  output logic [31:0]       pay_data,
  output logic              pay_last
);
  hdr_t             dec_hdr;
  run_e             dec_mode;
  logic             accept;
  logic             in_run;
  logic [OFF_W-1:0] run_off;
  logic             run_last;
  run_e             run_mode;
  logic             take_hdr;
  logic             take_pay;

  hdr_t              hdr_q;
  logic              hdr_v_q;
  logic              pay_v_q;
  logic [OFF_W-1:0]  pay_off_q;
  logic [WORD_W-1:0] pay_dat_q;
  logic              pay_last_q;
  run_e              pay_mode_q;

  assign in_ready = 1'b1;
  assign accept   = in_valid;
  assign take_hdr = accept && !in_run;
  assign take_pay = accept && in_run;

  cmd_hdr_decode u_dec (
    .word (in_word),
    .hdr  (dec_hdr),
    .mode (dec_mode)
  );

  cmd_run_tracker u_trk (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .hdr_plen (dec_hdr.plen),
    .hdr_mode (dec_mode),
    .hdr_off  (dec_hdr.off),
    .hdr_mask (dec_hdr.mask),
    .in_run   (in_run),
    .run_off  (run_off),
    .run_last (run_last),
    .run_mode (run_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_v_q    <= 1'b0;
      pay_v_q    <= 1'b0;
      hdr_q      <= '0;
      pay_off_q  <= '0;
      pay_dat_q  <= '0;
      pay_last_q <= 1'b0;
      pay_mode_q <= RUN_FIX;
    end else begin
      hdr_v_q <= take_hdr;
      pay_v_q <= take_pay;
      if (take_hdr) hdr_q <= dec_hdr;
      if (take_pay) begin
        pay_off_q  <= run_off;
        pay_dat_q  <= in_word;
        pay_last_q <= run_last;
        pay_mode_q <= run_mode;
      end
    end
  end

  assign hdr_valid    = hdr_v_q;
  assign hdr_op       = hdr_q.op;
  assign hdr_class    = hdr_q.cls;
  assign hdr_offset   = hdr_q.off;
  assign hdr_mask     = hdr_q.mask;
  assign hdr_count    = hdr_q.cnt;
  assign hdr_imm      = hdr_q.imm;
  assign hdr_lock     = hdr_q.lock;
  assign hdr_lock_acq = hdr_q.acq;
  assign hdr_lock_rel = hdr_q.rel;
  assign hdr_insert   = hdr_q.ins;
  assign hdr_type     = hdr_q.typ;
  assign hdr_target   = hdr_q.target;
  assign hdr_plen     = hdr_q.plen;
  assign hdr_err      = hdr_q.err;
  assign pay_valid    = pay_v_q;
  assign pay_offset   = pay_off_q;
  assign pay_data     = pay_dat_q;
  assign pay_last     = pay_last_q;

  p_excl_strobes_r1: assert property (@(posedge clk) disable iff (rst)
    !(hdr_valid && pay_valid));

  p_strobe_needs_input_r11: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid || pay_valid) |-> $past(in_valid));

  p_step_offset_r2: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && $past(pay_valid) && pay_mode_q == RUN_INC)
      |-> (pay_offset == OFF_W'($past(pay_offset) + OFF_W'(1))));

  p_fixed_offset_r3: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && $past(pay_valid) && pay_mode_q == RUN_FIX)
      |-> (pay_offset == $past(pay_offset)));

  p_last_ends_run_r13: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && pay_last) |=> !pay_valid);

  p_empty_run_r10: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_plen == '0) |=> !pay_valid);

  p_err_no_payload_r9: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && hdr_err) |-> (hdr_plen == '0));
endmodule

// File: tb/tb_cmd_stream_decoder.sv
`timescale 1ns/1ps
module tb_cmd_stream_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        hdr_valid;
  logic [3:0]  hdr_op;
  logic [9:0]  hdr_class;
  logic [11:0] hdr_offset;
  logic [15:0] hdr_mask, hdr_count, hdr_imm, hdr_plen;
  logic [7:0]  hdr_lock;
  logic        hdr_lock_acq, hdr_lock_rel, hdr_insert, hdr_type, hdr_err;
  logic [31:0] hdr_target;
  logic        pay_valid, pay_last;
  logic [11:0] pay_offset;
  logic [31:0] pay_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  int exp_q[$];
  int e_op, e_cls, e_off, e_mask, e_cnt, e_imm, e_lock, e_acq, e_rel, e_ins, e_typ, e_plen, e_err;
  logic [31:0] e_tgt;

  always #10 clk = ~clk;

  cmd_stream_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .hdr_valid(hdr_valid), .hdr_op(hdr_op), .hdr_class(hdr_class), .hdr_offset(hdr_offset),
    .hdr_mask(hdr_mask), .hdr_count(hdr_count), .hdr_imm(hdr_imm), .hdr_lock(hdr_lock),
    .hdr_lock_acq(hdr_lock_acq), .hdr_lock_rel(hdr_lock_rel), .hdr_insert(hdr_insert),
    .hdr_type(hdr_type), .hdr_target(hdr_target), .hdr_plen(hdr_plen), .hdr_err(hdr_err),
    .pay_valid(pay_valid), .pay_offset(pay_offset), .pay_data(pay_data), .pay_last(pay_last)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural header model: fields, then the list of payload offsets
  task automatic model_header(input logic [31:0] w);
    int op, off, sub;
    op  = int'(w >> 28);
    off = int'((w >> 16) & 32'hfff);
    sub = int'((w >> 24) & 32'hf);
    e_op = op; e_cls = 0; e_off = 0; e_mask = 0; e_cnt = 0; e_imm = 0; e_lock = 0;
    e_acq = 0; e_rel = 0; e_ins = 0; e_typ = 0; e_plen = 0; e_err = 0; e_tgt = '0;
    if (op == 0 || op == 3) begin
      e_off  = off;
      e_mask = (op == 0) ? int'(w & 32'h3f) : int'(w & 32'hffff);
      if (op == 0) e_cls = int'((w >> 6) & 32'h3ff);
      for (int b = 0; b < 16; b++)
        if ((e_mask >> b) & 1) exp_q.push_back((off + b) % 4096);
      e_plen = exp_q.size();
    end else if (op == 1 || op == 2) begin
      e_off = off; e_cnt = int'(w & 32'hffff); e_plen = e_cnt;
      for (int k = 0; k < e_cnt; k++) exp_q.push_back(op == 1 ? (off + k) % 4096 : off);
    end else if (op == 4) begin
      e_off = off; e_imm = int'(w & 32'hffff);
    end else if (op == 5) begin
      e_tgt = w << 4;
    end else if (op == 6) begin
      e_off = off; e_ins = int'(w[15]); e_typ = int'(w[14]); e_cnt = int'(w & 32'h3fff);
      e_plen = 1; exp_q.push_back(off);
    end else if (op == 14) begin
      if (sub == 0) begin e_acq = 1; e_lock = int'(w & 32'hff); end
      else if (sub == 1) begin e_rel = 1; e_lock = int'(w & 32'hff); end
      else e_err = 1;
    end else begin
      e_err = 1;
    end
  endtask

  // called at a falling edge; result is compared one rising edge later
  task automatic step(input logic v, input logic [31:0] w, input string tag);
    logic eh, ep, el;
    int eo;
    eh = 1'b0; ep = 1'b0; el = 1'b0; eo = 0;
    if (v) begin
      if (exp_q.size() == 0) begin
        eh = 1'b1;
        model_header(w);
      end else begin
        ep = 1'b1;
        eo = exp_q.pop_front();
        el = (exp_q.size() == 0);
      end
    end
    in_valid = v;
    in_word  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "hdr_valid", hdr_valid, eh);
    chk(tag, "pay_valid", pay_valid, ep);
    if (eh) begin
      chk("R1", "hdr_op", hdr_op, e_op);
      chk(tag, "hdr_class", hdr_class, e_cls);
      chk(tag, "hdr_offset", hdr_offset, e_off);
      chk(tag, "hdr_mask", hdr_mask, e_mask);
      chk(tag, "hdr_count", hdr_count, e_cnt);
      chk(tag, "hdr_imm", hdr_imm, e_imm);
      chk(tag, "hdr_lock", hdr_lock, e_lock);
      chk(tag, "hdr_lock_acq", hdr_lock_acq, e_acq);
      chk(tag, "hdr_lock_rel", hdr_lock_rel, e_rel);
      chk(tag, "hdr_insert", hdr_insert, e_ins);
      chk(tag, "hdr_type", hdr_type, e_typ);
      chk(tag, "hdr_target", hdr_target, e_tgt);
      chk("R13", "hdr_plen", hdr_plen, e_plen);
      chk(tag, "hdr_err", hdr_err, e_err);
    end
    if (ep) begin
      chk(tag, "pay_offset", pay_offset, eo);
      chk(tag, "pay_data", pay_data, w);
      chk("R13", "pay_last", pay_last, el);
    end
  endtask

  task automatic send_run(input logic [31:0] h, input int n, input string tag);
    step(1'b1, h, tag);
    for (int k = 0; k < n; k++) step(1'b1, 32'hA5000000 + 32'(k), tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "hdr_valid after reset", hdr_valid, 0);
    chk("R12", "pay_valid after reset", pay_valid, 0);
    rst = 1'b0;

    // R5: class select with mask 101001, then with zero mask
    send_run(32'h0020_5569, 3, "R5");
    step(1'b1, 32'h0030_4000, "R5");
    step(1'b1, 32'h4011_0022, "R6");

    // R2: stepping write wrapping past 0xFFF, with an idle cycle inside (R11)
    step(1'b1, 32'h1FFE_0003, "R2");
    step(1'b1, 32'h1111_0000, "R2");
    step(1'b0, 32'h4000_0000, "R11");
    step(1'b1, 32'h2222_0000, "R2");
    step(1'b1, 32'h3333_0000, "R2");
    step(1'b0, 32'hFFFF_FFFF, "R11");

    // R3: fixed write
    send_run(32'h2100_0002, 2, "R3");
    // R4: masked writes, sparse mask and empty mask
    send_run(32'h3040_8001, 2, "R4");
    send_run(32'h3FF8_0300, 2, "R4");
    step(1'b1, 32'h3050_0000, "R4");
    // R6, R7
    step(1'b1, 32'h4123_BEEF, "R6");
    step(1'b1, 32'h5ABC_DEF1, "R7");
    // R8: gather, one payload word
    send_run(32'h6456_C123, 1, "R8");
    send_run(32'h6007_0005, 1, "R8");
    // R9: extended
    step(1'b1, 32'hE000_00A5, "R9");
    step(1'b1, 32'hE100_003C, "R9");
    step(1'b1, 32'hE700_0011, "R9");
    // R10: undefined opcodes, parsing resumes
    step(1'b1, 32'h9FFF_FFFF, "R10");
    step(1'b1, 32'hFFFF_0003, "R10");
    step(1'b1, 32'h7000_0001, "R10");
    step(1'b1, 32'h4001_0001, "R10");
    // R2: zero-count stepping write, then a longer run
    step(1'b1, 32'h1020_0000, "R2");
    send_run(32'h10A0_0014, 20, "R2");
    // R14: header fields of other kinds read zero (covered by field compares)
    step(1'b1, 32'h4FFF_FFFF, "R14");
    step(1'b1, 32'h5FFF_FFFF, "R14");

    // R12: reset in the middle of a payload run
    step(1'b1, 32'h1300_0005, "R12");
    step(1'b1, 32'h0000_1111, "R12");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    chk("R12", "hdr_valid in reset", hdr_valid, 0);
    chk("R12", "pay_valid in reset", pay_valid, 0);
    step(1'b1, 32'h4055_1234, "R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule